// File: doc/BRIEF.md
# Linked-List Context Save/Restore Engine

This block moves a processor's register context between the register file and memory. Memory holds a pool of fixed 64-byte frames, each of sixteen 32-bit words. Free frames form a singly linked list chained through word 0 of each frame. Saved contexts form a second list, chained through the same word. Two 32-bit registers inside the block track the two lists. The context link register names the most recently saved frame. The free head register names the next free frame. A 20-bit link value, taken from the low 20 bits of either register, selects a frame.

A save takes the head frame from the free list and reads its word 0 to learn the next free frame. It then writes sixteen context words into the frame and updates both link registers. Saves come in two layouts: an upper layout and a lower layout. A restore reads the sixteen words of the frame named by the context link register and writes the general registers back. It keeps the saved link word and the saved status word in holding registers. It then writes the free head into word 0 of that frame, which pushes the frame back onto the free list.

Memory is reached one word at a time through a request/acknowledge port. The register file is reached through one combinational read port and one write port. Reset values for the two link registers are parameters.

Top module: `ctx_engine`

## Requirements
- R1: A 20-bit link value L gives the frame base address {L[19:16], 6'b0, L[15:0], 6'b0}. Word k of a frame is at base + 4*k. A save uses the free head's low 20 bits as L. A restore uses the context link's low 20 bits.
- R2: A save first issues one read (mem_we_o=0) of the frame base. Only then does it issue any write. The word read becomes the next free head.
- R3: An upper save (op_i=0) writes words 0..15 in ascending address order. Word 0 is the old context link and word 1 is status_i. Words 2..15 take register file indices 26,27,8,9,10,11,28,29,30,31,12,13,14,15. Indices 0..15 are data registers and 16..31 are address registers.
- R4: A lower save (op_i=1) writes word 0 as the old context link and word 1 as register index 27, not status_i. Words 2..15 take indices 18,19,0,1,2,3,20,21,22,23,4,5,6,7.
- R5: After a save, the context link becomes {prio_i, old link[23:20], old free head[19:0]}. The free head becomes the word read in R2.
- R6: A restore (op_i=2) reads words 0..15 in ascending order. Word 0 is held as the new link. Word 1 appears on rest_status_o. Each word 2..15 is written to the register file index given by the upper layout of R3.
- R7: After its sixteen reads, a restore writes the current free head into word 0 of the same frame.
- R8: After a restore, free head bits [31:20] are unchanged and bits [19:0] take the old context link's bits [19:0]. The context link takes the word 0 that was read.
- R9: A save requested while free head bits [19:0] are zero makes no memory access. It raises empty_err_o and done_o for one cycle and leaves both link registers unchanged.
- R10: A memory request holds its address until acknowledged. busy_o is high from the cycle after an accepted start until the last access is acknowledged.
- R11: done_o pulses for exactly one cycle per completed operation. start_i is ignored while busy_o is high. start_i with op_i=3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start an operation |
| op_i | input | 2 | 0 upper save, 1 lower save, 2 restore, 3 none |
| prio_i | input | 8 | Current priority number placed in the link on save |
| status_i | input | 32 | Current status word, saved by an upper save |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| empty_err_o | output | 1 | One-cycle pulse: save refused, free list empty |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the access |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| rf_rd_idx_o | output | 5 | Register file read index |
| rf_rd_data_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_wr_idx_o | output | 5 | Register file write index |
| rf_wr_data_o | output | 32 | Register file write data |
| ctx_link_o | output | 32 | Context link register |
| free_head_o | output | 32 | Free head register |
| rest_status_o | output | 32 | Status word recovered by the last restore |

## Verification
Every register holds a value derived from its own index, so a wrong index in either layout shows up as a wrong data word. The upper and lower saves run on different frames. This separates the two layouts and the word-1 choice between status and register 27. The saves alternate between zero-wait and two-wait acknowledges, which exposes accesses that advance without an acknowledge. The restore reads back the frame the lower save wrote. It is checked for frame selection, for upper-layout write-back and for the free-list push. A free-list link of zero in the second frame sets up the empty-list refusal. Starts issued while busy and starts with op_i=3 check that no operation is accepted when it should not be.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int FRAME_WORDS = 16;
  localparam int WORD_IDX_W  = $clog2(FRAME_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LINK_RD,
    ST_SAVE_WR,
    ST_REST_RD,
    ST_REST_FREE
  } ctx_state_e;

  typedef enum logic [1:0] {
    OP_SAVE_UP = 2'd0,
    OP_SAVE_LO = 2'd1,
    OP_RESTORE = 2'd2,
    OP_NONE    = 2'd3
  } ctx_op_e;
endpackage

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen #(
  parameter int AW    = 32,
  parameter int LW    = 20,
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int WIW   = 4
) (
  input  logic [LW-1:0]  link_i,
  input  logic [WIW-1:0] word_i,
  output logic [AW-1:0]  addr_o
);
  localparam int FRAME_SH = WIW + 2;
  localparam int GAP_W    = AW - SEG_W - OFF_W - FRAME_SH;

  logic [AW-1:0] base;

  // segment bits go to the top, offset bits sit just above the frame size
  assign base   = {link_i[LW-1 -: SEG_W], {GAP_W{1'b0}}, link_i[OFF_W-1:0], {FRAME_SH{1'b0}}};
  assign addr_o = base | {{(AW-FRAME_SH){1'b0}}, word_i, 2'b00};
endmodule

// File: rtl/ctx_word_map.sv
module ctx_word_map #(
  parameter int WIW = 4,
  parameter int RIW = 5
) (
  input  logic           lower_i,
  input  logic [WIW-1:0] word_i,
  output logic           is_reg_o,
  output logic [RIW-1:0] idx_o
);
  logic [1:0]     grp;
  logic [1:0]     pos;
  logic [RIW-2:0] num;
  logic           is_addr;

  assign grp = word_i[3:2];
  assign pos = word_i[1:0];

  always_comb begin
    is_reg_o = 1'b1;
    is_addr  = 1'b1;
    num      = '0;
    if (word_i < WIW'(2)) begin
      // word 0 is the link; word 1 is status (upper) or address reg 11 (lower)
      is_reg_o = lower_i && (word_i == WIW'(1));
      num      = (RIW-1)'(11);
    end else begin
      is_addr = (grp == 2'd0) || (grp == 2'd2);
      num     = (lower_i ? (RIW-1)'(0) : (RIW-1)'(8))
              + (((grp == 2'd0) || (grp == 2'd1)) ? (RIW-1)'(0) : (RIW-1)'(4))
              + (RIW-1)'(pos);
    end
  end

  assign idx_o = {is_addr, num};
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_pkg::*;
#(
  parameter int WIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     op_i,
  input  logic           free_empty_i,
  input  logic           mem_ack_i,
  output ctx_state_e     state_o,
  output logic [WIW-1:0] word_o,
  output logic           lower_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic           link_cap_o,
  output logic           rd_cap_o,
  output logic           save_commit_o,
  output logic           rest_commit_o
);
  localparam logic [WIW-1:0] LAST = WIW'(FRAME_WORDS - 1);

  ctx_state_e     state_q, state_d;
  logic [WIW-1:0] cnt_q, cnt_d;
  logic           lower_q, lower_d;
  logic           done_q, done_d;
  logic           err_q, err_d;
  logic           cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lower_d = lower_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && op_i != OP_NONE) begin
          cnt_en = 1'b1;
          cnt_d  = '0;
          if (op_i == OP_RESTORE) begin
            lower_d = 1'b0;
            state_d = ST_REST_RD;
          end else if (free_empty_i) begin
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            lower_d = (op_i == OP_SAVE_LO);
            state_d = ST_LINK_RD;
          end
        end
      end
      ST_LINK_RD: begin
        if (mem_ack_i) state_d = ST_SAVE_WR;
      end
      ST_SAVE_WR: begin
        if (mem_ack_i) begin
          cnt_en = 1'b1;
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + WIW'(1);
          end
        end
      end
      ST_REST_RD: begin
        if (mem_ack_i) begin
          cnt_en = 1'b1;
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            state_d = ST_REST_FREE;
          end else begin
            cnt_d = cnt_q + WIW'(1);
          end
        end
      end
      ST_REST_FREE: begin
        if (mem_ack_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lower_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      lower_q <= lower_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign state_o       = state_q;
  assign word_o        = cnt_q;
  assign lower_o       = lower_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign link_cap_o    = (state_q == ST_LINK_RD) && mem_ack_i;
  assign rd_cap_o      = (state_q == ST_REST_RD) && mem_ack_i;
  assign save_commit_o = (state_q == ST_SAVE_WR) && mem_ack_i && (cnt_q == LAST);
  assign rest_commit_o = (state_q == ST_REST_FREE) && mem_ack_i;

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (state_q == ST_IDLE) && done_q);
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_LINK_RD) |=> state_q != ST_LINK_RD);
  p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !mem_ack_i) |=> (state_q == $past(state_q)) && $stable(cnt_q));
endmodule

// File: rtl/ctx_engine.sv
module ctx_engine
  import ctx_pkg::*;
#(
  parameter int          DW            = 32,
  parameter int          AW            = 32,
  parameter int          LW            = 20,
  parameter int          PRIO_W        = 8,
  parameter int          RIW           = 5,
  parameter logic [31:0] RST_CTX_LINK  = 32'h0,
  parameter logic [31:0] RST_FREE_HEAD = 32'h0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     op_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [DW-1:0]  status_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           empty_err_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [RIW-1:0] rf_rd_idx_o,
  input  logic [DW-1:0]  rf_rd_data_i,
  output logic           rf_we_o,
  output logic [RIW-1:0] rf_wr_idx_o,
  output logic [DW-1:0]  rf_wr_data_o,
  output logic [DW-1:0]  ctx_link_o,
  output logic [DW-1:0]  free_head_o,
  output logic [DW-1:0]  rest_status_o
);
  localparam int WIW  = WORD_IDX_W;
  localparam int MIDW = DW - PRIO_W - LW;

  logic [1:0]   rst_sync_q;
  logic         rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ctx_state_e     state;
  logic [WIW-1:0] word;
  logic           lower, link_cap, rd_cap, save_commit, rest_commit;
  logic           map_is_reg;
  logic [RIW-1:0] map_idx;
  logic [LW-1:0]  sel_link;

  logic [DW-1:0] link_q, link_d;
  logic [DW-1:0] free_q, free_d;
  logic [DW-1:0] next_free_q, new_link_q, rest_status_q;
  logic          link_en;

  ctx_seq #(.WIW(WIW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .start_i       (start_i),
    .op_i          (op_i),
    .free_empty_i  (free_q[LW-1:0] == '0),
    .mem_ack_i     (mem_ack_i),
    .state_o       (state),
    .word_o        (word),
    .lower_o       (lower),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (empty_err_o),
    .link_cap_o    (link_cap),
    .rd_cap_o      (rd_cap),
    .save_commit_o (save_commit),
    .rest_commit_o (rest_commit)
  );

  ctx_word_map #(.WIW(WIW), .RIW(RIW)) u_map (
    .lower_i  (lower),
    .word_i   (word),
    .is_reg_o (map_is_reg),
    .idx_o    (map_idx)
  );

  assign sel_link = ((state == ST_REST_RD) || (state == ST_REST_FREE)) ? link_q[LW-1:0]
                                                                        : free_q[LW-1:0];

  ctx_addr_gen #(.AW(AW), .LW(LW), .WIW(WIW)) u_addr (
    .link_i (sel_link),
    .word_i (word),
    .addr_o (mem_addr_o)
  );

  assign mem_req_o = (state != ST_IDLE);
  assign mem_we_o  = (state == ST_SAVE_WR) || (state == ST_REST_FREE);

  always_comb begin
    mem_wdata_o = '0;
    if (state == ST_SAVE_WR) begin
      if (word == '0)                     mem_wdata_o = link_q;
      else if (!map_is_reg)               mem_wdata_o = status_i;
      else                                mem_wdata_o = rf_rd_data_i;
    end else if (state == ST_REST_FREE) begin
      mem_wdata_o = free_q;
    end
  end

  assign rf_rd_idx_o  = map_idx;
  assign rf_wr_idx_o  = map_idx;
  assign rf_wr_data_o = mem_rdata_i;
  assign rf_we_o      = rd_cap && map_is_reg;

  // link register next state
  always_comb begin
    link_en = save_commit || rest_commit;
    link_d  = link_q;
    free_d  = free_q;
    if (save_commit) begin
      link_d = {prio_i, link_q[DW-PRIO_W-1 -: MIDW], free_q[LW-1:0]};
      free_d = next_free_q;
    end else if (rest_commit) begin
      link_d = new_link_q;
      free_d = {free_q[DW-1:LW], link_q[LW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      link_q        <= RST_CTX_LINK;
      free_q        <= RST_FREE_HEAD;
      next_free_q   <= '0;
      new_link_q    <= '0;
      rest_status_q <= '0;
    end else begin
      if (link_en) begin
        link_q <= link_d;
        free_q <= free_d;
      end
      if (link_cap)                        next_free_q   <= mem_rdata_i;
      if (rd_cap && word == WIW'(0))       new_link_q    <= mem_rdata_i;
      if (rd_cap && word == WIW'(1))       rest_status_q <= mem_rdata_i;
    end
  end

  assign ctx_link_o    = link_q;
  assign free_head_o   = free_q;
  assign rest_status_o = rest_status_q;

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o) && $stable(mem_we_o));
  p_frame_shape_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_req_o |-> (mem_addr_o[27:22] == 6'd0) && (mem_addr_o[1:0] == 2'd0));
  p_save_link_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    save_commit |=> link_q[LW-1:0] == $past(free_q[LW-1:0]));
  p_free_hi_keep_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    rest_commit |=> free_q[DW-1:LW] == $past(free_q[DW-1:LW]));
  p_no_access_on_empty_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    empty_err_o |-> !mem_req_o && $stable(link_q) && $stable(free_q));
  p_read_before_write_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(mem_req_o) |-> !mem_we_o);
endmodule

// File: tb/sim_ctx_engine.sv
module sim_ctx_engine;
  localparam logic [31:0] INIT_LINK = 32'h1122_3344;
  localparam logic [31:0] INIT_FREE = 32'hABC3_0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd3;
  logic [7:0]  prio = 8'h5A;
  logic [31:0] status = 32'h1234_5678;
  logic        busy, done, err, req, we, ack;
  logic [31:0] addr, wdata, rdata;
  logic [4:0]  rd_idx, wr_idx;
  logic [31:0] rd_data, wr_data;
  logic        rf_we;
  logic [31:0] link, free_h, rstat;

  always #5 clk = ~clk;

  ctx_engine #(.RST_CTX_LINK(INIT_LINK), .RST_FREE_HEAD(INIT_FREE)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .prio_i(prio),
    .status_i(status), .busy_o(busy), .done_o(done), .empty_err_o(err),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .rf_rd_idx_o(rd_idx),
    .rf_rd_data_i(rd_data), .rf_we_o(rf_we), .rf_wr_idx_o(wr_idx),
    .rf_wr_data_o(wr_data), .ctx_link_o(link), .free_head_o(free_h),
    .rest_status_o(rstat)
  );

  // memory model: window of 256 words at 0x3000_0000
  logic [31:0] mem [0:255];
  logic [31:0] rf  [0:31];
  int          lat = 0;
  int          wcnt = 0;
  logic [31:0] log_a [0:63];
  logic [31:0] log_d [0:63];
  logic        log_w [0:63];
  int          log_n = 0;
  int          done_cnt = 0;
  int          tests = 0;
  int          fails = 0;

  assign ack     = req && (wcnt == lat);
  assign rdata   = mem[addr[9:2]];
  assign rd_data = rf[rd_idx];

  always @(posedge clk) begin
    if (req && !ack) wcnt <= wcnt + 1;
    else             wcnt <= 0;
    if (req && ack) begin
      if (log_n < 64) begin
        log_a[log_n] <= addr;
        log_d[log_n] <= we ? wdata : rdata;
        log_w[log_n] <= we;
      end
      log_n <= log_n + 1;
      if (we) mem[addr[9:2]] <= wdata;
    end
    if (rf_we) rf[wr_idx] <= wr_data;
    if (done) done_cnt <= done_cnt + 1;
  end

  // expected register indices per frame word (words 2..15)
  int up_map [2:15] = '{26,27,8,9,10,11,28,29,30,31,12,13,14,15};
  int lo_map [2:15] = '{18,19,0,1,2,3,20,21,22,23,4,5,6,7};

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [31:0] frame_of(input logic [19:0] l);
    return {l[19:16], 6'b0, l[15:0], 6'b0};
  endfunction

  task automatic launch(input logic [1:0] o);
    @(negedge clk);
    log_n = 0;
    op    = o;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 500 && !done; i++) @(negedge clk);
    chk(done, "R11 done seen", {31'b0, done}, 32'd1);
    @(negedge clk);
    chk(!done, "R11 done single cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic check_save(input bit lower_l, input logic [31:0] old_link,
                            input logic [31:0] old_free, input logic [31:0] nxt);
    logic [31:0] base, e;
    base = frame_of(old_free[19:0]);
    chk(log_n == 17, "R2 access count", log_n, 17);
    chk(!log_w[0] && log_a[0] == base, "R2 link read first", log_a[0], base);
    for (int k = 0; k < 16; k++) begin
      if (k == 0)                 e = old_link;
      else if (k == 1 && !lower_l) e = status;
      else if (k == 1)            e = rf[27];
      else                        e = lower_l ? rf[lo_map[k]] : rf[up_map[k]];
      chk(log_w[k+1] && log_a[k+1] == base + 32'(4*k), lower_l ? "R4 address" : "R3 address",
          log_a[k+1], base + 32'(4*k));
      chk(log_d[k+1] == e, lower_l ? "R4 word data" : "R3 word data", log_d[k+1], e);
    end
    e = {prio, old_link[23:20], old_free[19:0]};
    chk(link == e, "R5 link after save", link, e);
    chk(free_h == nxt, "R5 free head after save", free_h, nxt);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !req, "R10 reset idle", {28'b0, busy, done, err, req}, 0);
    chk(link == INIT_LINK, "R5 reset link", link, INIT_LINK);
    chk(free_h == INIT_FREE, "R8 reset free", free_h, INIT_FREE);
  endtask

  task automatic t_save_upper();
    logic [31:0] ol, ofr;
    ol = link; ofr = free_h;
    lat = 0;
    mem[frame_of(ofr[19:0]) >> 2 & 32'hFF] = 32'h0003_0011;
    launch(2'd0);
    chk(busy, "R10 busy after start", {31'b0, busy}, 1);
    wait_done();
    chk(!busy, "R10 busy low at end", {31'b0, busy}, 0);
    check_save(1'b0, ol, ofr, 32'h0003_0011);
  endtask

  task automatic t_save_lower();
    logic [31:0] ol, ofr;
    ol = link; ofr = free_h;
    lat = 2;
    chk(frame_of(ofr[19:0]) == 32'h3000_0440, "R1 frame address", frame_of(ofr[19:0]), 32'h3000_0440);
    mem[frame_of(ofr[19:0]) >> 2 & 32'hFF] = 32'h0000_0000;
    prio = 8'hC3;
    launch(2'd1);
    wait_done();
    check_save(1'b1, ol, ofr, 32'h0);
  endtask

  task automatic t_empty();
    logic [31:0] ol, ofr;
    int d0;
    ol = link; ofr = free_h; d0 = done_cnt;
    launch(2'd0);
    chk(err && done && !busy, "R9 error pulse", {29'b0, err, done, busy}, 3'b110);
    @(negedge clk);
    chk(!err && !done, "R9 error single cycle", {30'b0, err, done}, 0);
    repeat (3) @(negedge clk);
    chk(log_n == 0, "R9 no memory access", log_n, 0);
    chk(link == ol && free_h == ofr, "R9 links unchanged", link, ol);
    chk(done_cnt == d0 + 1, "R11 one done for refused save", done_cnt, d0 + 1);
  endtask

  task automatic t_op_none();
    int d0;
    d0 = done_cnt;
    launch(2'd3);
    repeat (6) @(negedge clk);
    chk(!busy && log_n == 0 && done_cnt == d0, "R11 op 3 ignored", log_n, 0);
  endtask

  task automatic t_restore();
    logic [31:0] ol, ofr, base;
    logic [31:0] snap [0:15];
    int d0;
    ol = link; ofr = free_h; base = frame_of(ol[19:0]);
    for (int k = 0; k < 16; k++) snap[k] = mem[(base >> 2) & 32'hFF];
    for (int k = 0; k < 16; k++) snap[k] = mem[((base >> 2) + k) & 32'hFF];
    lat = 1;
    d0 = done_cnt;
    launch(2'd2);
    repeat (3) @(negedge clk);
    start = 1'b1; op = 2'd0;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, "R11 start while busy ignored", done_cnt, d0 + 1);
    chk(log_n == 17, "R6 access count", log_n, 17);
    for (int k = 0; k < 16; k++)
      chk(!log_w[k] && log_a[k] == base + 32'(4*k), "R6 read address", log_a[k], base + 32'(4*k));
    for (int k = 2; k < 16; k++)
      chk(rf[up_map[k]] == snap[k], "R6 register write back", rf[up_map[k]], snap[k]);
    chk(rstat == snap[1], "R6 restored status", rstat, snap[1]);
    chk(log_w[16] && log_a[16] == base && log_d[16] == ofr, "R7 free push write", log_d[16], ofr);
    chk(link == snap[0], "R8 link after restore", link, snap[0]);
    chk(free_h == {ofr[31:20], ol[19:0]}, "R8 free after restore", free_h, {ofr[31:20], ol[19:0]});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    for (int i = 0; i < 32; i++)  rf[i]  = 32'h5000_0000 | (32'(i) << 8) | 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_save_upper();
    t_save_lower();
    t_empty();
    t_op_none();
    t_restore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule